// File: doc/BRIEF.md
# Modem-Handshake Transmit Gate

This block sits between a byte transmit buffer and the serial line, and it gates transmission with an active-low request-to-send output and an active-low clear-to-send input. Software fills a 32-byte buffer, which is split into two 16-byte pools, and then pulses a transmit command. The block drives request-to-send low, waits until the synchronised clear-to-send grants permission, and then shifts the bytes out one bit per clock.

There are two modes. In frame mode, if clear-to-send goes away partway through a frame, the frame is aborted. The line sends at least seven ones, and the whole frame starts again from its first byte once permission returns. This retry only works while the pool that holds the frame's first byte has not yet been released. Once that pool has been released, the block instead drops the frame, flushes the buffer, releases request-to-send and raises a repeat-request flag.

In character mode, the byte in flight always completes. The next byte waits until permission returns. Three sticky interrupt flags report the following events:
- a clear-to-send edge, which is maskable;
- the repeat request;
- everything sent.

Top module: `hs_tx_gate`

## Requirements
- R1: `rts_n` is 1 after reset. It goes to 0 once `xmit_cmd` is pulsed with the buffer non-empty. It returns to 1 after the last queued byte has been shifted out.
- R2: While `rts_force_en` is 1, `rts_n` equals `rts_force_lvl`, whatever transmit requests are pending.
- R3: No data bit is sent, and `tx_vld` stays 0, while `cts_n` is 1 (permission withheld), even with data queued and commanded.
- R4: Each byte is sent least significant bit first, one bit per clock, with `tx_vld` high for each data bit. When no data bit is being sent, `txd` is 1.
- R5: In frame mode (`char_mode`=0), losing permission before the pool holding the frame's first byte is released stops the byte in flight. At least seven idle-one cycles follow, and the whole frame is then re-sent from its first byte exactly once.
- R6: In frame mode, losing permission after that pool was released flushes all queued bytes and sets `irq_flags[1]`. `rts_n` returns to 1, and nothing more is sent when permission returns.
- R7: In character mode (`char_mode`=1), losing permission lets the current byte finish. The next byte goes out only after permission returns, and no byte is repeated.
- R8: `irq_flags[0]` is set by a falling or rising transition of the synchronised `cts_n`, but only while `cts_irq_en` is 1.
- R9: `irq_flags[2]` is set when the buffer has drained and the shifter has gone idle.
- R10: Each flag stays set until a 1 is written on the matching `irq_clr` bit. It is then 0 on the next cycle.
- R11: The buffer holds 32 bytes. `fifo_full` is 1 at 32 bytes, and a write while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_mode | input | 1 | 1 = character mode, 0 = frame mode |
| wr_en | input | 1 | Write strobe into the transmit buffer |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Buffer holds 32 bytes |
| xmit_cmd | input | 1 | Transmit command pulse |
| rts_force_en | input | 1 | Software override of request-to-send |
| rts_force_lvl | input | 1 | Level driven on `rts_n` while overridden |
| rts_n | output | 1 | Request-to-send, active low |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| cts_irq_en | input | 1 | Enables the clear-to-send change flag |
| irq_clr | input | 3 | Write-one-to-clear for `irq_flags` |
| irq_flags | output | 3 | [0] CTS change, [1] repeat request, [2] all sent |
| txd | output | 1 | Serial data, idle high |
| tx_vld | output | 1 | High while a data bit is on `txd` |

## Verification
The bench first removes clear-to-send three bit times into the first byte of a frame. It expects one clean copy of the frame afterwards. A design that rewound to the wrong byte would show a duplicated or missing byte, and a design that skipped the abort ones would restart in under seven cycles.

A second frame loses permission just after its first pool has been released. A design that retried there would send data again instead of flushing and raising the repeat flag. In character mode the same drop must leave exactly one finished byte. The bench also fills the buffer to exactly 32 bytes plus one rejected write, which would expose an off-by-one in the full test.

// File: rtl/hs_pkg.sv
package hs_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_ABORT} tx_state_e;
   localparam int FLG_CTS  = 0;
   localparam int FLG_XMR  = 1;
   localparam int FLG_ALLS = 2;
   localparam int NFLAGS   = 3;
endpackage

// File: rtl/hs_cts_sync.sv
module hs_cts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic level_n,
   output logic toggle
);
   logic [STAGES-1:0] chain;
   logic              last;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= pin_n;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= chain[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last <= 1'b1;
      else        last <= chain[STAGES-1];

   assign level_n = chain[STAGES-1];
   assign toggle  = level_n ^ last;
endmodule

// File: rtl/hs_pool_fifo.sv
module hs_pool_fifo #(
   parameter int W     = 8,
   parameter int POOL  = 16,
   parameter int NPOOL = 2,
   localparam int DEPTH = POOL * NPOOL,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic [PW-1:0] base_ptr,
   input  logic [AW-1:0] rd_addr,
   output logic [PW-1:0] wr_ptr,
   output logic          full,
   output logic [W-1:0]  rd_data
);
   logic [W-1:0] mem [DEPTH];
   logic         accept;

   assign full   = (wr_ptr - base_ptr) == PW'(DEPTH);
   assign accept = wr_en && !full;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      wr_ptr <= '0;
      else if (accept) wr_ptr <= wr_ptr + 1'b1;

   always_ff @(posedge clk)
      if (accept) mem[wr_ptr[AW-1:0]] <= wr_data;

   assign rd_data = mem[rd_addr];

   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> (wr_ptr == $past(wr_ptr)))
      else $error("write accepted while full");
endmodule

// File: rtl/hs_tx_ctrl.sv
module hs_tx_ctrl import hs_pkg::*; #(
   parameter int W         = 8,
   parameter int POOL      = 16,
   parameter int NPOOL     = 2,
   parameter int ABORT_LEN = 7,
   localparam int AW  = $clog2(POOL * NPOOL),
   localparam int PW  = AW + 1,
   localparam int PBW = $clog2(POOL),
   localparam int BW  = $clog2(W),
   localparam int CW  = $clog2(ABORT_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          char_mode,
   input  logic          cts_ok,
   input  logic          xmit_cmd,
   input  logic [PW-1:0] wr_ptr,
   input  logic [W-1:0]  rd_data,
   output logic [PW-1:0] base_ptr,
   output logic [AW-1:0] rd_addr,
   output logic          txd,
   output logic          tx_vld,
   output logic          armed,
   output logic          xmr_evt,
   output logic          alls_evt
);
   tx_state_e     state;
   logic [W-1:0]  sh;
   logic [BW-1:0] bitcnt;
   logic [CW-1:0] abcnt;
   logic [PW-1:0] cur_ptr, cur_nxt;
   logic          released, last_bit, pool_end;

   assign cur_nxt  = cur_ptr + 1'b1;
   assign last_bit = bitcnt == BW'(W - 1);
   assign pool_end = &cur_ptr[PBW-1:0];
   assign rd_addr  = (state == ST_SEND && last_bit) ? cur_nxt[AW-1:0] : cur_ptr[AW-1:0];
   assign tx_vld   = state == ST_SEND;
   assign txd      = tx_vld ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sh       <= '1;
         bitcnt   <= '0;
         abcnt    <= '0;
         base_ptr <= '0;
         cur_ptr  <= '0;
         armed    <= 1'b0;
         released <= 1'b0;
         xmr_evt  <= 1'b0;
         alls_evt <= 1'b0;
      end else begin
         xmr_evt  <= 1'b0;
         alls_evt <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (armed && cts_ok && (cur_ptr != wr_ptr)) begin
                  sh     <= rd_data;
                  bitcnt <= '0;
                  state  <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (!char_mode && !cts_ok) begin
                  if (released) begin
                     base_ptr <= wr_ptr;
                     cur_ptr  <= wr_ptr;
                     armed    <= 1'b0;
                     released <= 1'b0;
                     xmr_evt  <= 1'b1;
                     state    <= ST_IDLE;
                  end else begin
                     cur_ptr <= base_ptr;
                     abcnt   <= '0;
                     state   <= ST_ABORT;
                  end
               end else if (!last_bit) begin
                  sh     <= {1'b1, sh[W-1:1]};
                  bitcnt <= bitcnt + 1'b1;
               end else begin
                  bitcnt  <= '0;
                  cur_ptr <= cur_nxt;
                  if (!char_mode && pool_end) released <= 1'b1;
                  if (char_mode || released || pool_end) base_ptr <= cur_nxt;
                  if (cur_nxt == wr_ptr) begin
                     armed    <= 1'b0;
                     released <= 1'b0;
                     alls_evt <= 1'b1;
                     base_ptr <= cur_nxt;
                     state    <= ST_IDLE;
                  end else if (char_mode && !cts_ok) begin
                     state <= ST_IDLE;
                  end else begin
                     sh <= rd_data;
                  end
               end
            end
            ST_ABORT: begin
               if (abcnt == CW'(ABORT_LEN - 1)) state <= ST_IDLE;
               else                             abcnt <= abcnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
         if (xmit_cmd && (cur_ptr != wr_ptr)) armed <= 1'b1;
      end
   end

   a_r3_start_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_vld) |-> $past(cts_ok))
      else $error("transmission started without permission");

   a_r5_abort_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND && !char_mode && !cts_ok && !released)
      |=> (state == ST_ABORT && cur_ptr == $past(base_ptr)))
      else $error("frame abort did not rewind to frame start");

   a_r6_flush_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEND && !char_mode && !cts_ok && released)
      |=> (xmr_evt && cur_ptr == base_ptr && state == ST_IDLE))
      else $error("released pool did not flush");

   a_r7_char_completes: assert property (@(posedge clk) disable iff (!rst_n)
      (char_mode && tx_vld && !last_bit) |=> tx_vld)
      else $error("character cut short");
endmodule

// File: rtl/hs_tx_gate.sv
module hs_tx_gate import hs_pkg::*; #(
   parameter int DATA_W      = 8,
   parameter int POOL_BYTES  = 16,
   parameter int POOL_COUNT  = 2,
   parameter int SYNC_STAGES = 2,
   parameter int ABORT_ONES  = 7,
   localparam int AW = $clog2(POOL_BYTES * POOL_COUNT),
   localparam int PW = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_mode,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              fifo_full,
   input  logic              xmit_cmd,
   input  logic              rts_force_en,
   input  logic              rts_force_lvl,
   output logic              rts_n,
   input  logic              cts_n,
   input  logic              cts_irq_en,
   input  logic [NFLAGS-1:0] irq_clr,
   output logic [NFLAGS-1:0] irq_flags,
   output logic              txd,
   output logic              tx_vld
);
   initial begin
      assert ((1 << $clog2(POOL_BYTES)) == POOL_BYTES && POOL_BYTES >= 2)
         else $error("POOL_BYTES must be a power of two");
      assert ((1 << $clog2(POOL_COUNT)) == POOL_COUNT && POOL_COUNT >= 2)
         else $error("POOL_COUNT must be a power of two, at least 2");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES below 2");
      assert (ABORT_ONES >= 1 && DATA_W >= 2) else $error("bad ABORT_ONES or DATA_W");
   end

   logic              cts_lvl_n, cts_tog, cts_ok;
   logic [PW-1:0]     wr_ptr, base_ptr;
   logic [AW-1:0]     rd_addr;
   logic [DATA_W-1:0] rd_data;
   logic              armed, xmr_evt, alls_evt;
   logic [NFLAGS-1:0] set_vec;

   hs_cts_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(cts_n), .level_n(cts_lvl_n), .toggle(cts_tog));

   assign cts_ok = !cts_lvl_n;

   hs_pool_fifo #(.W(DATA_W), .POOL(POOL_BYTES), .NPOOL(POOL_COUNT)) i_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .base_ptr(base_ptr),
      .rd_addr(rd_addr), .wr_ptr(wr_ptr), .full(fifo_full), .rd_data(rd_data));

   hs_tx_ctrl #(.W(DATA_W), .POOL(POOL_BYTES), .NPOOL(POOL_COUNT), .ABORT_LEN(ABORT_ONES)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .char_mode(char_mode), .cts_ok(cts_ok), .xmit_cmd(xmit_cmd),
      .wr_ptr(wr_ptr), .rd_data(rd_data), .base_ptr(base_ptr), .rd_addr(rd_addr),
      .txd(txd), .tx_vld(tx_vld), .armed(armed), .xmr_evt(xmr_evt), .alls_evt(alls_evt));

   assign rts_n = rts_force_en ? rts_force_lvl : !armed;

   assign set_vec[FLG_CTS]  = cts_tog && cts_irq_en;
   assign set_vec[FLG_XMR]  = xmr_evt;
   assign set_vec[FLG_ALLS] = alls_evt;

   for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)          irq_flags[i] <= 1'b0;
         else if (set_vec[i]) irq_flags[i] <= 1'b1;
         else if (irq_clr[i]) irq_flags[i] <= 1'b0;

      a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_flags[i] && !irq_clr[i]) |=> irq_flags[i])
         else $error("flag dropped without clear");
   end

   a_r8_cts_flag_masked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[FLG_CTS]) |-> $past(cts_irq_en))
      else $error("CTS change flag set while masked");

   a_r6_rts_released: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_flags[FLG_XMR]) && !rts_force_en && !$past(xmit_cmd)) |-> rts_n)
      else $error("request still active after repeat request");
endmodule

// File: tb/test_hs_tx_gate.sv
module test_hs_tx_gate;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       char_mode = 1'b0, wr_en = 1'b0, xmit_cmd = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rts_force_en = 1'b0, rts_force_lvl = 1'b0, cts_n = 1'b1, cts_irq_en = 1'b0;
   logic [2:0] irq_clr = '0;
   logic       fifo_full, rts_n, txd, tx_vld;
   logic [2:0] irq_flags;

   int checks = 0, failures = 0, wcount = 0, rx_cnt = 0, bitc = 0, vld_cycles = 0;
   logic [7:0] acc = '0;
   logic [7:0] rx_buf [0:255];
   bit done = 1'b0;

   // {mode, first byte, second byte}
   localparam logic [16:0] VEC [0:5] = '{17'h0_A5_3C, 17'h1_00_FF, 17'h0_81_7E,
                                         17'h1_C3_01, 17'h0_FF_00, 17'h1_5A_96};

   always #(CLK_PERIOD/2) clk = ~clk;

   hs_tx_gate i_hs_tx_gate (
      .clk(clk), .rst_n(rst_n), .char_mode(char_mode), .wr_en(wr_en), .wr_data(wr_data),
      .fifo_full(fifo_full), .xmit_cmd(xmit_cmd), .rts_force_en(rts_force_en),
      .rts_force_lvl(rts_force_lvl), .rts_n(rts_n), .cts_n(cts_n), .cts_irq_en(cts_irq_en),
      .irq_clr(irq_clr), .irq_flags(irq_flags), .txd(txd), .tx_vld(tx_vld));

   always @(negedge clk) begin
      if (!rst_n) bitc = 0;
      else if (tx_vld) begin
         vld_cycles++;
         acc = {txd, acc[7:1]};
         bitc++;
         if (bitc == 8) begin
            rx_buf[rx_cnt[7:0]] = acc;
            rx_cnt++;
            bitc = 0;
         end
      end else bitc = 0;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      wr_data = b; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      wcount++;
   endtask

   task automatic cmd();
      xmit_cmd = 1'b1;
      @(negedge clk);
      xmit_cmd = 1'b0;
   endtask

   task automatic clr(input int idx);
      irq_clr[idx] = 1'b1;
      @(negedge clk);
      irq_clr = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_flag(input int idx, input int lim);
      for (int k = 0; k < lim && !irq_flags[idx]; k++) @(negedge clk);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      summary();
   end

   initial begin
      int start, gap, rel, snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(rts_n == 1'b1, "R1 reset rts", rts_n, 1);
      chk(txd == 1'b1 && tx_vld == 1'b0, "R4 reset line idle", {txd, tx_vld}, 2);
      chk(irq_flags == 3'b000, "R10 reset flags", irq_flags, 0);
      chk(fifo_full == 1'b0, "R11 reset full", fifo_full, 0);

      // masked CTS edges
      cts_n = 1'b0; idle(5); cts_n = 1'b1; idle(5);
      chk(irq_flags[0] == 1'b0, "R8 masked edge ignored", irq_flags[0], 0);

      // request without permission
      push(8'h96); push(8'h69); cmd(); idle(2);
      chk(rts_n == 1'b0, "R1 request asserted", rts_n, 0);
      idle(40);
      chk(vld_cycles == 0 && rx_cnt == 0, "R3 held without cts", vld_cycles, 0);
      cts_irq_en = 1'b1;
      cts_n = 1'b0;
      idle(4);
      chk(irq_flags[0] == 1'b1, "R8 falling edge flagged", irq_flags[0], 1);
      wait_flag(2, 200);
      chk(irq_flags[2] == 1'b1, "R9 all sent", irq_flags[2], 1);
      chk(rx_cnt == 2, "R4 byte count", rx_cnt, 2);
      chk(rx_buf[0] == 8'h96 && rx_buf[1] == 8'h69, "R4 lsb first data",
          {rx_buf[0], rx_buf[1]}, 16'h9669);
      chk(rts_n == 1'b1, "R1 request dropped after drain", rts_n, 1);
      chk(irq_flags[0] == 1'b1, "R10 flag sticky", irq_flags[0], 1);
      clr(0); clr(2);
      chk(irq_flags == 3'b000, "R10 w1c clears", irq_flags, 0);

      // vector table, permission held
      for (int v = 0; v < 6; v++) begin
         start = rx_cnt;
         char_mode = VEC[v][16];
         push(VEC[v][15:8]); push(VEC[v][7:0]); cmd();
         wait_flag(2, 200);
         chk(rx_cnt == start + 2, "R4 vector count", rx_cnt - start, 2);
         chk(rx_buf[start[7:0]] == VEC[v][15:8] && rx_buf[start[7:0]+8'd1] == VEC[v][7:0],
             "R4 vector data", {rx_buf[start[7:0]], rx_buf[start[7:0]+8'd1]}, VEC[v][15:0]);
         chk(rts_n == 1'b1, "R1 vector rts release", rts_n, 1);
         clr(2);
      end

      // software override
      rts_force_en = 1'b1; rts_force_lvl = 1'b0; idle(1);
      chk(rts_n == 1'b0, "R2 forced low", rts_n, 0);
      rts_force_lvl = 1'b1; idle(1);
      chk(rts_n == 1'b1, "R2 forced high", rts_n, 1);
      rts_force_en = 1'b0;

      // frame abort and retransmit
      cts_irq_en = 1'b0;
      char_mode = 1'b0;
      cts_n = 1'b1; idle(5);
      start = rx_cnt;
      push(8'h11); push(8'h22); push(8'h33); cmd();
      cts_n = 1'b0;
      for (int k = 0; k < 100 && !tx_vld; k++) @(negedge clk);
      cts_n = 1'b1;
      for (int k = 0; k < 100 && tx_vld; k++) @(negedge clk);
      chk(rts_n == 1'b0, "R5 request held over abort", rts_n, 0);
      cts_n = 1'b0;
      gap = 0;
      for (int k = 0; k < 100 && !tx_vld; k++) begin @(negedge clk); gap++; end
      chk(gap >= 7, "R5 abort ones", gap, 7);
      wait_flag(2, 300);
      chk(rx_cnt == start + 3, "R5 single resend count", rx_cnt - start, 3);
      chk(rx_buf[start[7:0]] == 8'h11 && rx_buf[start[7:0]+8'd1] == 8'h22 &&
          rx_buf[start[7:0]+8'd2] == 8'h33, "R5 resend from first byte",
          rx_buf[start[7:0]], 8'h11);
      chk(irq_flags[1] == 1'b0, "R5 no repeat request", irq_flags[1], 0);
      clr(2);

      // pool already released
      cts_n = 1'b1; idle(5);
      start = rx_cnt;
      rel = 16 - (wcount % 16);
      for (int k = 0; k < 20; k++) push(8'h40 + 8'(k));
      cmd();
      cts_n = 1'b0;
      for (int k = 0; k < 2000 && rx_cnt < start + rel + 1; k++) @(negedge clk);
      cts_n = 1'b1;
      idle(12);
      chk(irq_flags[1] == 1'b1, "R6 repeat request flag", irq_flags[1], 1);
      chk(rts_n == 1'b1, "R6 request released", rts_n, 1);
      chk(tx_vld == 1'b0, "R6 transmitter stopped", tx_vld, 0);
      snap = rx_cnt;
      cts_n = 1'b0;
      idle(60);
      chk(rx_cnt == snap && tx_vld == 1'b0, "R6 buffer flushed", rx_cnt - snap, 0);
      clr(1);

      // character mode hold
      char_mode = 1'b1;
      cts_n = 1'b1; idle(5);
      start = rx_cnt;
      push(8'h44); push(8'h55); push(8'h66); cmd();
      cts_n = 1'b0;
      for (int k = 0; k < 100 && !tx_vld; k++) @(negedge clk);
      cts_n = 1'b1;
      idle(30);
      chk(rx_cnt == start + 1, "R7 current char completes", rx_cnt - start, 1);
      chk(rx_buf[start[7:0]] == 8'h44, "R7 completed char value", rx_buf[start[7:0]], 8'h44);
      cts_n = 1'b0;
      wait_flag(2, 300);
      chk(rx_cnt == start + 3 && rx_buf[start[7:0]+8'd1] == 8'h55 &&
          rx_buf[start[7:0]+8'd2] == 8'h66, "R7 resume without repeat", rx_cnt - start, 3);
      clr(2);

      // capacity
      char_mode = 1'b0;
      cts_n = 1'b1; idle(5);
      start = rx_cnt;
      for (int k = 1; k <= 32; k++) push(8'(k));
      chk(fifo_full == 1'b1, "R11 full at 32", fifo_full, 1);
      push(8'h21);
      chk(fifo_full == 1'b1, "R11 still full", fifo_full, 1);
      cmd();
      cts_n = 1'b0;
      wait_flag(2, 1000);
      chk(rx_cnt == start + 32, "R11 extra write dropped", rx_cnt - start, 32);
      chk(rx_buf[start[7:0]+8'd31] == 8'h20, "R11 last stored byte",
          rx_buf[start[7:0]+8'd31], 8'h20);
      clr(2);
      chk(irq_flags[2] == 1'b0, "R10 clear all sent", irq_flags[2], 0);

      summary();
   end
endmodule